// File: doc/BRIEF.md
# Ring Buffer DMA Write Pointer Manager

This block owns the write pointer of a single DMA stream that fills a circular region of memory. It decides when a 128-byte burst may start, offers the burst start address to a bus-side engine, and moves the pointer forward by one burst only when that engine reports the burst as complete. A burst that never completes, for example because it failed on the bus, leaves the pointer where it was. When the advanced pointer lands on the end address, which lies one past the last byte of the ring, it jumps straight back to the start address.

Software steers the stream through a pause limit and an interrupt threshold. No burst starts while the pointer equals the limit, so software moves the limit forward as it consumes data. When the pointer becomes equal to the interrupt threshold, which has a finer 8-byte grain, and the stream's interrupt is enabled, a sticky pending bit is set. That bit drives the interrupt output through a global master enable. An init pulse reloads the pointer from the start address and tells the data buffer to discard its contents.

A burst passes through four states. `ST_IDLE` moves to `ST_REQ` when every start condition holds. `ST_REQ` raises the request and moves to `ST_BUSY` on grant, or back to `ST_IDLE` if a start condition lapses or init arrives. `ST_BUSY` returns to `ST_IDLE` on done and advances the pointer. On init without done it moves to `ST_DRAIN`. `ST_DRAIN` waits for done and then returns to `ST_IDLE` without advancing the pointer.

Top module: `ring_wptr_mgr`

## Requirements
- R1: After reset the pointer is 0, and the request, busy and interrupt outputs are all low.
- R2: The request is high only while the stream enable and global DMA enable are high, no error is pending, at least 16 words are buffered, the pointer differs from the limit (limit block address × 16 in word units), and init is low.
- R3: The burst address is the pointer in 128-byte block units. A granted request makes busy high from the next cycle until the burst completes, and request and busy are never high together.
- R4: A done pulse during a live burst advances the pointer by 16 words (128 bytes) at the next clock edge. The pointer changes at no other time except on init.
- R5: When the advanced pointer would equal the end address (end block × 16 words), the pointer becomes the start address instead.
- R6: While the pointer equals the limit, no request is made. Moving the limit away lets requests resume.
- R7: Init loads the start address into the pointer, raises the flush output for that cycle and withdraws an ungranted request. A burst already granted keeps busy high until its done, and that done does not advance the pointer.
- R8: Dropping the stream enable withdraws an ungranted request at once. A burst already granted still completes and advances the pointer.
- R9: The pending bit sets in the cycle the pointer is loaded with a value equal to the threshold (word units), and it stays set until the clear input is high. A set and a clear in the same cycle leave it set.
- R10: The interrupt output is high exactly when the pending bit is set and the master interrupt enable is high.
- R11: With the stream interrupt enable low, reaching the threshold leaves the pending bit clear.
- R12: A done pulse while no burst is live has no effect on the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stream_en_i | input | 1 | Stream enable |
| dma_en_i | input | 1 | Global DMA enable |
| dma_err_i | input | 1 | A DMA error is pending; blocks new bursts |
| init_i | input | 1 | Init pulse: reload pointer, flush buffer |
| fill_i | input | FILL_W (8) | Number of 64-bit words buffered |
| start_blk_i | input | BW (25) | Ring start, 128-byte units |
| end_blk_i | input | BW (25) | Ring end (one past last), 128-byte units |
| limit_blk_i | input | BW (25) | Pause limit, 128-byte units |
| irq_thr_i | input | PW (29) | Interrupt threshold, 8-byte units |
| irq_en_i | input | 1 | Stream interrupt enable |
| irq_clr_i | input | 1 | Clear pending interrupt |
| irq_master_i | input | 1 | Global interrupt enable |
| burst_grant_i | input | 1 | Bus engine accepts the request |
| burst_done_i | input | 1 | Burst completed successfully |
| burst_req_o | output | 1 | Burst request |
| burst_addr_o | output | BW (25) | Burst start address, 128-byte units |
| ptr_o | output | PW (29) | Current write pointer, 8-byte units |
| busy_o | output | 1 | A granted burst has not completed |
| flush_o | output | 1 | Discard buffered data |
| irq_o | output | 1 | Interrupt |

## Verification
On every cycle the assertions check these things. The request never coincides with busy, with the limit, with an error or with init. A grant always leads to busy. The pointer moves only after done or init, and an advance never leaves it on the end address. The pending bit holds until cleared and never rises without the stream interrupt enable. The interrupt never rises without the master enable. Some behaviour needs a sequence of stimuli, and only the bench scenarios show it. These are the exact pointer arithmetic across a full wrap, resuming after the limit moves, a drained burst that does not advance after init, and a set winning over a clear in the same cycle.

// File: rtl/ring_wptr_pkg.sv
package ring_wptr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BUSY  = 2'd2,
        ST_DRAIN = 2'd3
    } wp_state_e;

endpackage

// File: rtl/ring_wptr_fsm.sv
module ring_wptr_fsm
    import ring_wptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      can_start_i,
    input  logic      init_i,
    input  logic      grant_i,
    input  logic      done_i,
    output wp_state_e state_o,
    output logic      req_o,
    output logic      busy_o,
    output logic      adv_o
);

    wp_state_e state_q;
    wp_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (can_start_i) state_d = ST_REQ;
            end
            ST_REQ: begin
                if (!can_start_i)  state_d = ST_IDLE;
                else if (grant_i)  state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (done_i)        state_d = ST_IDLE;
                else if (init_i)   state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (done_i)        state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        req_o  = 1'b0;
        busy_o = 1'b0;
        adv_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_REQ:   req_o = can_start_i;
            ST_BUSY: begin
                busy_o = 1'b1;
                adv_o  = done_i && !init_i;
            end
            ST_DRAIN: busy_o = 1'b1;
            default:  ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/ring_wptr_ptr.sv
module ring_wptr_ptr #(
    parameter int PW  = 29,
    parameter int BW  = 25,
    parameter int SUB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          adv_i,
    input  logic [BW-1:0] start_blk_i,
    input  logic [BW-1:0] end_blk_i,
    output logic [PW-1:0] ptr_o,
    output logic [PW-1:0] ptr_nxt_o,
    output logic          load_o
);

    localparam logic [PW-1:0] STEP = {{(PW-1){1'b0}}, 1'b1} << SUB;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] start_w;
    logic [PW-1:0] end_w;
    logic [PW-1:0] sum;

    assign start_w = {start_blk_i, {SUB{1'b0}}};
    assign end_w   = {end_blk_i, {SUB{1'b0}}};
    assign sum     = ptr_q + STEP;

    always_comb begin
        if (init_i)            ptr_nxt_o = start_w;
        else if (sum == end_w) ptr_nxt_o = start_w;
        else                   ptr_nxt_o = sum;
    end

    assign load_o = init_i || adv_i;

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (load_o) ptr_q <= ptr_nxt_o;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/ring_wptr_irq.sv
module ring_wptr_irq #(
    parameter int PW = 29
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [PW-1:0] nxt_i,
    input  logic [PW-1:0] thr_i,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic          master_i,
    output logic          pend_o,
    output logic          irq_o
);

    logic pend_q;
    logic hit;

    assign hit = load_i && en_i && (nxt_i == thr_i);

    // a new hit wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (hit)   pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q && master_i;

endmodule

// File: rtl/ring_wptr_mgr.sv
module ring_wptr_mgr
    import ring_wptr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 7,
    parameter int WRD_SHIFT = 3,
    parameter int FILL_W    = 8,
    parameter int PW        = ADDR_W - WRD_SHIFT,
    parameter int BW        = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_en_i,
    input  logic              dma_en_i,
    input  logic              dma_err_i,
    input  logic              init_i,
    input  logic [FILL_W-1:0] fill_i,
    input  logic [BW-1:0]     start_blk_i,
    input  logic [BW-1:0]     end_blk_i,
    input  logic [BW-1:0]     limit_blk_i,
    input  logic [PW-1:0]     irq_thr_i,
    input  logic              irq_en_i,
    input  logic              irq_clr_i,
    input  logic              irq_master_i,
    input  logic              burst_grant_i,
    input  logic              burst_done_i,
    output logic              burst_req_o,
    output logic [BW-1:0]     burst_addr_o,
    output logic [PW-1:0]     ptr_o,
    output logic              busy_o,
    output logic              flush_o,
    output logic              irq_o
);

    localparam int SUB   = BLK_SHIFT - WRD_SHIFT;
    localparam int BEATS = 1 << SUB;
    localparam logic [FILL_W-1:0] BEATS_F = FILL_W'(BEATS);

    wp_state_e     state;
    logic          can_start;
    logic          adv;
    logic          load;
    logic          pend_q;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_nxt;
    logic [PW-1:0] limit_w;

    assign limit_w   = {limit_blk_i, {SUB{1'b0}}};
    assign can_start = stream_en_i && dma_en_i && !dma_err_i && !init_i
                       && (fill_i >= BEATS_F) && (ptr_q != limit_w);

    ring_wptr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .can_start_i (can_start),
        .init_i      (init_i),
        .grant_i     (burst_grant_i),
        .done_i      (burst_done_i),
        .state_o     (state),
        .req_o       (burst_req_o),
        .busy_o      (busy_o),
        .adv_o       (adv)
    );

    ring_wptr_ptr #(.PW(PW), .BW(BW), .SUB(SUB)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .adv_i       (adv),
        .start_blk_i (start_blk_i),
        .end_blk_i   (end_blk_i),
        .ptr_o       (ptr_q),
        .ptr_nxt_o   (ptr_nxt),
        .load_o      (load)
    );

    ring_wptr_irq #(.PW(PW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .nxt_i    (ptr_nxt),
        .thr_i    (irq_thr_i),
        .en_i     (irq_en_i),
        .clr_i    (irq_clr_i),
        .master_i (irq_master_i),
        .pend_o   (pend_q),
        .irq_o    (irq_o)
    );

    assign ptr_o        = ptr_q;
    assign burst_addr_o = ptr_q[PW-1:SUB];
    assign flush_o      = init_i;

endmodule

// File: rtl/ring_wptr_chk.sv
module ring_wptr_chk #(
    parameter int PW  = 29,
    parameter int BW  = 25,
    parameter int SUB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_err_i,
    input logic          init_i,
    input logic [BW-1:0] start_blk_i,
    input logic [BW-1:0] end_blk_i,
    input logic [BW-1:0] limit_blk_i,
    input logic          irq_en_i,
    input logic          irq_clr_i,
    input logic          irq_master_i,
    input logic          burst_grant_i,
    input logic          burst_done_i,
    input logic          burst_req_o,
    input logic [PW-1:0] ptr_o,
    input logic          busy_o,
    input logic          irq_o,
    input logic          adv,
    input logic          pend_q
);

    // R2 / R6: never request at the limit or with an error pending
    assert_req_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req_o |-> (!dma_err_i && ptr_o != {limit_blk_i, {SUB{1'b0}}}));

    // R3: request and busy exclusive; grant leads to busy
    assert_req_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(burst_req_o && busy_o));
    assert_grant_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_req_o && burst_grant_i) |=> busy_o);

    // R4 / R12: pointer moves only after done or init
    assert_ptr_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_o) |-> $past(burst_done_i || init_i));

    // R5: an advance never leaves the pointer on the end address
    assert_no_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adv) && $stable(end_blk_i) && (start_blk_i != end_blk_i))
        |-> ptr_o != {end_blk_i, {SUB{1'b0}}});

    // R7: init withdraws the request
    assert_init_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |-> !burst_req_o);

    // R9: pending holds until cleared
    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !irq_clr_i) |=> pend_q);

    // R11: pending never rises without stream interrupt enable
    assert_pend_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(irq_en_i));

    // R10: interrupt needs master enable
    assert_irq_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_master_i);

endmodule

bind ring_wptr_mgr ring_wptr_chk #(.PW(PW), .BW(BW), .SUB(SUB)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_err_i     (dma_err_i),
    .init_i        (init_i),
    .start_blk_i   (start_blk_i),
    .end_blk_i     (end_blk_i),
    .limit_blk_i   (limit_blk_i),
    .irq_en_i      (irq_en_i),
    .irq_clr_i     (irq_clr_i),
    .irq_master_i  (irq_master_i),
    .burst_grant_i (burst_grant_i),
    .burst_done_i  (burst_done_i),
    .burst_req_o   (burst_req_o),
    .ptr_o         (ptr_o),
    .busy_o        (busy_o),
    .irq_o         (irq_o),
    .adv           (adv),
    .pend_q        (pend_q)
);

// File: tb/ring_wptr_mgr_bench.sv
module ring_wptr_mgr_bench;

    localparam int PW = 29;
    localparam int BW = 25;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stream_en = 0, dma_en = 0, dma_err = 0, init = 0;
    logic [FW-1:0] fill = '0;
    logic [BW-1:0] start_blk = '0, end_blk = '0, limit_blk = '0;
    logic [PW-1:0] irq_thr = '0;
    logic          irq_en = 0, irq_clr = 0, irq_master = 0;
    logic          grant = 0, done = 0;
    logic          req, busy, flush, irq;
    logic [BW-1:0] addr;
    logic [PW-1:0] ptr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ring_wptr_mgr u_ring_wptr_mgr (
        .clk(clk), .rst_n(rst_n), .stream_en_i(stream_en), .dma_en_i(dma_en),
        .dma_err_i(dma_err), .init_i(init), .fill_i(fill),
        .start_blk_i(start_blk), .end_blk_i(end_blk), .limit_blk_i(limit_blk),
        .irq_thr_i(irq_thr), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
        .irq_master_i(irq_master), .burst_grant_i(grant), .burst_done_i(done),
        .burst_req_o(req), .burst_addr_o(addr), .ptr_o(ptr), .busy_o(busy),
        .flush_o(flush), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_req(input string rq);
        bit seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (req) begin seen = 1; break; end
            tick();
        end
        chk(seen, rq, "request appears", seen, 1);
    endtask

    task automatic no_req(input string rq, input int n);
        bit any = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (req) any = 1;
        end
        chk(!any, rq, "no request", any, 0);
    endtask

    // grant, then done; checks address, busy and the pointer after
    task automatic do_burst(input string rq, input int exp_blk, input int exp_ptr,
                            input bit clr_with_done);
        wait_req(rq);
        chk(addr == BW'(exp_blk), "R3", "burst address", addr, exp_blk);
        grant = 1;
        tick();
        grant = 0;
        chk(busy == 1'b1, "R3", "busy after grant", busy, 1);
        chk(req == 1'b0, "R3", "no request while busy", req, 0);
        done = 1;
        irq_clr = clr_with_done;
        tick();
        done = 0;
        irq_clr = 0;
        chk(busy == 1'b0, "R3", "busy cleared on done", busy, 0);
        chk(ptr == PW'(exp_ptr), rq, "pointer after burst", ptr, exp_ptr);
    endtask

    task automatic do_init();
        init = 1;
        #1;
        chk(flush == 1'b1, "R7", "flush during init", flush, 1);
        chk(req == 1'b0, "R7", "no request during init", req, 0);
        tick();
        init = 0;
        chk(ptr == {start_blk, 4'b0}, "R7", "pointer reloaded", ptr, {start_blk, 4'b0});
    endtask

    task automatic t_reset();
        tick();
        chk(ptr == '0, "R1", "reset pointer", ptr, 0);
        chk(!req && !busy && !irq, "R1", "reset outputs", {req, busy, irq}, 0);
        rst_n = 1;
        tick();
    endtask

    task automatic t_wrap();
        start_blk = 4; end_blk = 7; limit_blk = 100; irq_thr = 1;
        stream_en = 1; dma_en = 1;
        do_init();
        fill = 16;
        do_burst("R4", 4, 80, 0);
        do_burst("R4", 5, 96, 0);
        do_burst("R5", 6, 64, 0);
        fill = 0;
    endtask

    task automatic t_gating();
        fill = 15;              no_req("R2", 5);
        fill = 16; dma_err = 1; no_req("R2", 5);
        dma_err = 0; dma_en = 0; no_req("R2", 5);
        dma_en = 1; stream_en = 0; no_req("R2", 5);
        stream_en = 1;
        do_burst("R2", 4, 80, 0);
        fill = 0;
    endtask

    task automatic t_limit();
        limit_blk = 6; fill = 16;
        do_burst("R6", 5, 96, 0);
        no_req("R6", 6);
        limit_blk = 100;
        do_burst("R6", 6, 64, 0);
        fill = 0;
    endtask

    task automatic t_init();
        fill = 16;
        do_burst("R7", 4, 80, 0);
        wait_req("R7");
        do_init();
        chk(busy == 1'b0, "R7", "idle after init", busy, 0);
        wait_req("R7");
        grant = 1; tick(); grant = 0;
        init = 1; tick(); init = 0;
        chk(busy == 1'b1, "R7", "busy held while draining", busy, 1);
        chk(ptr == PW'(64), "R7", "pointer at start during drain", ptr, 64);
        fill = 0;
        done = 1; tick(); done = 0;
        chk(busy == 1'b0, "R7", "drain ends on done", busy, 0);
        chk(ptr == PW'(64), "R7", "drained burst does not advance", ptr, 64);
    endtask

    task automatic t_enable();
        fill = 16;
        wait_req("R8");
        stream_en = 0;
        #1;
        chk(req == 1'b0, "R8", "request withdrawn", req, 0);
        tick();
        chk(busy == 1'b0, "R8", "no burst after withdraw", busy, 0);
        stream_en = 1;
        wait_req("R8");
        grant = 1; tick(); grant = 0;
        stream_en = 0;
        chk(busy == 1'b1, "R8", "burst live after disable", busy, 1);
        done = 1; tick(); done = 0;
        chk(ptr == PW'(80), "R8", "in-flight burst advances", ptr, 80);
        no_req("R8", 4);
        stream_en = 1;
        fill = 0;
    endtask

    task automatic t_stray_done();
        tick();
        done = 1; tick(); done = 0;
        tick();
        chk(ptr == PW'(80), "R12", "stray done ignored", ptr, 80);
    endtask

    task automatic t_irq();
        irq_thr = 96; irq_en = 1; irq_master = 0; fill = 16;
        do_burst("R9", 5, 96, 0);
        fill = 0;
        chk(irq == 1'b0, "R10", "masked interrupt", irq, 0);
        irq_master = 1;
        #1;
        chk(irq == 1'b1, "R10", "interrupt with master", irq, 1);
        tick(); tick(); tick();
        chk(irq == 1'b1, "R9", "pending is sticky", irq, 1);
        irq_clr = 1; tick(); irq_clr = 0;
        chk(irq == 1'b0, "R9", "pending cleared", irq, 0);
        irq_en = 0; irq_thr = 64; fill = 16;
        do_burst("R11", 6, 64, 0);
        fill = 0;
        tick();
        chk(irq == 1'b0, "R11", "no pending when disabled", irq, 0);
        irq_en = 1; irq_thr = 80; fill = 16;
        do_burst("R9", 4, 80, 1);
        fill = 0;
        chk(irq == 1'b1, "R9", "set beats simultaneous clear", irq, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_wrap();
        t_gating();
        t_limit();
        t_init();
        t_enable();
        t_stray_done();
        t_irq();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule